// File: doc/BRIEF.md
# VLAN-Aware Egress Mask Resolver

This block decides where a packet goes in a switch with sixteen front ports and one CPU port. For each packet it takes the ingress port number, the forwarding-table lookup result and a broadcast flag. The lookup result is a hit/miss bit, a static bit, the entry's 17-bit port mask and the entry's VLAN ID. The block also reads each port's 6-bit VLAN ID, a server port mask and two CPU-copy enables, all as plain inputs. It returns a 17-bit egress mask one clock later. Bits 0 to 15 are the front ports and bit 16 is the CPU port.

VLAN filtering is active only while every front port carries a non-zero VLAN ID. When it is active, floods stay inside the ingress port's VLAN, and server ports join every flood. A unicast to a learned entry in another VLAN is either diverted to the CPU or dropped. A static table entry always wins over these rules.

Top module: `vlan_fwd_resolver`

## Requirements
- R1: VLAN mode is on exactly when all sixteen port VLAN IDs are non-zero. If any of them is zero, no VLAN rule or server-mask rule is applied.
- R2: In VLAN mode, a broadcast, or a lookup miss, is flooded to every front port whose VLAN ID equals the ingress port's VLAN ID.
- R3: In VLAN mode, front ports whose server mask bit is set are added to every broadcast/miss flood, whatever their VLAN ID.
- R4: A broadcast sets CPU bit 16 exactly when cpu_bcast_en is 1. A lookup miss that is not a broadcast never sets bit 16.
- R5: A hit on a static entry yields the entry's port mask, all 17 bits, with no CPU bit added. This takes priority over the broadcast flag and over every VLAN rule.
- R6: In VLAN mode, a non-static, non-broadcast hit whose entry VLAN ID differs from the ingress port's VLAN ID yields 17'h10000 when xvlan_cpu_en is 1, and an all-zero mask when it is 0.
- R7: A non-static, non-broadcast hit with matching VLAN IDs, or any such hit with VLAN mode off, yields the entry's port mask.
- R8: With VLAN mode off, a broadcast or miss floods all front ports other than the ingress port.
- R9: The ingress port's bit is always zero in the output mask, whichever rule produced the mask.
- R10: A packet presented with in_valid high in one cycle gives out_valid high and its mask in the next cycle. out_valid is low in any cycle that follows a cycle without in_valid, and out_mask then keeps its last value.
- R11: The synchronous active-high reset clears out_valid and out_mask to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Packet descriptor valid |
| in_port | input | 4 | Ingress front port number |
| is_bcast | input | 1 | Packet is a broadcast |
| lkp_hit | input | 1 | Destination found in the table |
| lkp_static | input | 1 | Hit entry is static |
| lkp_mask | input | 17 | Entry port mask, bit 16 is CPU |
| lkp_vid | input | 6 | Entry VLAN ID |
| port_vids | input | 96 | Port i VLAN ID at bits [6i+5:6i] |
| srv_mask | input | 16 | Server port mask |
| cpu_bcast_en | input | 1 | Copy broadcasts to the CPU |
| xvlan_cpu_en | input | 1 | Send cross-VLAN unicast to the CPU |
| out_valid | output | 1 | Egress mask valid |
| out_mask | output | 17 | Egress port mask, bit 16 is CPU |

## Verification
Four properties are checked on every cycle. The output valid follows the input strobe by exactly one cycle, and the mask holds when no packet arrived. The ingress bit is never set. A static hit passes its entry mask through. With VLAN mode off, floods reach every other port. The outcomes that depend on VLAN ID comparisons can only be shown by the bench's directed scenarios. These are VLAN-confined floods, server-port inclusion, the CPU broadcast copy and the cross-VLAN divert-or-drop choice.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
    localparam int NUM_PORTS = 16;
    localparam int VID_W     = 6;
    localparam int PIDX_W    = $clog2(NUM_PORTS);
    localparam int MASK_W    = NUM_PORTS + 1;
    localparam int CPU_BIT   = NUM_PORTS;

    typedef logic [MASK_W-1:0] egress_mask_t;

    typedef struct packed {
        logic         valid;
        egress_mask_t mask;
    } vfr_state_t;
endpackage

// File: rtl/vfr_vid_ctrl.sv
module vfr_vid_ctrl #(
    parameter int NPORT = vfr_pkg::NUM_PORTS,
    parameter int VW    = vfr_pkg::VID_W,
    localparam int IW   = $clog2(NPORT)
) (
    input  logic [NPORT*VW-1:0] port_vids,
    input  logic [IW-1:0]       in_port,
    output logic                vlan_on,
    output logic [VW-1:0]       src_vid,
    output logic [NPORT-1:0]    same_vid
);
    logic [NPORT-1:0] vid_nz;

    always_comb begin
        src_vid = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (in_port == IW'(k)) src_vid = port_vids[k*VW +: VW];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign vid_nz[p]   = |port_vids[p*VW +: VW];
        assign same_vid[p] = (port_vids[p*VW +: VW] == src_vid);
    end

    assign vlan_on = &vid_nz;
endmodule

// File: rtl/vfr_flood.sv
module vfr_flood #(
    parameter int NPORT = vfr_pkg::NUM_PORTS,
    localparam int IW   = $clog2(NPORT)
) (
    input  logic [IW-1:0]    in_port,
    input  logic             vlan_on,
    input  logic [NPORT-1:0] same_vid,
    input  logic [NPORT-1:0] srv_mask,
    input  logic             is_bcast,
    input  logic             cpu_bcast_en,
    output logic [NPORT:0]   flood_mask
);
    logic [NPORT-1:0] member;

    for (genvar p = 0; p < NPORT; p++) begin : g_mem
        assign member[p] = (in_port != IW'(p)) &&
                           (!vlan_on || same_vid[p] || srv_mask[p]);
    end

    assign flood_mask = {is_bcast & cpu_bcast_en, member};
endmodule

// File: rtl/vfr_select.sv
module vfr_select #(
    parameter int NPORT = vfr_pkg::NUM_PORTS,
    parameter int VW    = vfr_pkg::VID_W,
    localparam int IW   = $clog2(NPORT)
) (
    input  logic [IW-1:0]  in_port,
    input  logic           vlan_on,
    input  logic [VW-1:0]  src_vid,
    input  logic           is_bcast,
    input  logic           lkp_hit,
    input  logic           lkp_static,
    input  logic [NPORT:0] lkp_mask,
    input  logic [VW-1:0]  lkp_vid,
    input  logic [NPORT:0] flood_mask,
    input  logic           xvlan_cpu_en,
    output logic [NPORT:0] sel_mask
);
    logic [NPORT:0] ingress_oh;
    logic [NPORT:0] raw;

    assign ingress_oh = (NPORT+1)'(1) << in_port;

    always_comb begin
        if (lkp_hit && lkp_static) begin
            raw = lkp_mask;
        end else if (is_bcast || !lkp_hit) begin
            raw = flood_mask;
        end else if (vlan_on && (lkp_vid != src_vid)) begin
            raw = '0;
            raw[NPORT] = xvlan_cpu_en;
        end else begin
            raw = lkp_mask;
        end
        sel_mask = raw & ~ingress_oh;
    end
endmodule

// File: rtl/vlan_fwd_resolver.sv
module vlan_fwd_resolver
    import vfr_pkg::*;
#(
    parameter int NPORT = NUM_PORTS,
    parameter int VW    = VID_W,
    localparam int IW   = $clog2(NPORT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [IW-1:0]       in_port,
    input  logic                is_bcast,
    input  logic                lkp_hit,
    input  logic                lkp_static,
    input  logic [NPORT:0]      lkp_mask,
    input  logic [VW-1:0]       lkp_vid,
    input  logic [NPORT*VW-1:0] port_vids,
    input  logic [NPORT-1:0]    srv_mask,
    input  logic                cpu_bcast_en,
    input  logic                xvlan_cpu_en,
    output logic                out_valid,
    output logic [NPORT:0]      out_mask
);
    typedef struct packed {
        logic           valid;
        logic [NPORT:0] mask;
    } st_t;

    logic             vlan_on;
    logic [VW-1:0]    src_vid;
    logic [NPORT-1:0] same_vid;
    logic [NPORT:0]   flood_mask;
    logic [NPORT:0]   sel_mask;
    st_t              st_d, st_q;

    vfr_vid_ctrl #(.NPORT(NPORT), .VW(VW)) vid_i (
        .port_vids (port_vids),
        .in_port   (in_port),
        .vlan_on   (vlan_on),
        .src_vid   (src_vid),
        .same_vid  (same_vid)
    );

    vfr_flood #(.NPORT(NPORT)) flood_i (
        .in_port      (in_port),
        .vlan_on      (vlan_on),
        .same_vid     (same_vid),
        .srv_mask     (srv_mask),
        .is_bcast     (is_bcast),
        .cpu_bcast_en (cpu_bcast_en),
        .flood_mask   (flood_mask)
    );

    vfr_select #(.NPORT(NPORT), .VW(VW)) sel_i (
        .in_port      (in_port),
        .vlan_on      (vlan_on),
        .src_vid      (src_vid),
        .is_bcast     (is_bcast),
        .lkp_hit      (lkp_hit),
        .lkp_static   (lkp_static),
        .lkp_mask     (lkp_mask),
        .lkp_vid      (lkp_vid),
        .flood_mask   (flood_mask),
        .xvlan_cpu_en (xvlan_cpu_en),
        .sel_mask     (sel_mask)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.mask = sel_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_mask  = st_q.mask;

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    hold_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_mask)));

    // R9
    no_ingress_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_mask[$past(in_port)] == 1'b0));

    // R5
    static_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lkp_hit && lkp_static) |=>
        (out_mask == ($past(lkp_mask) & ~((NPORT+1)'(1) << $past(in_port)))));

    // R8
    open_flood_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !vlan_on && !(lkp_hit && lkp_static) && (is_bcast || !lkp_hit)) |=>
        (out_mask[NPORT-1:0] == ~(NPORT'(1) << $past(in_port))));
endmodule

// File: tb/vlan_fwd_resolver_tb.sv
module vlan_fwd_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  in_port;
    logic        is_bcast, lkp_hit, lkp_static;
    logic [16:0] lkp_mask;
    logic [5:0]  lkp_vid;
    logic [95:0] port_vids;
    logic [15:0] srv_mask;
    logic        cpu_bcast_en, xvlan_cpu_en;
    logic        out_valid;
    logic [16:0] out_mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    vlan_fwd_resolver dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port),
        .is_bcast(is_bcast), .lkp_hit(lkp_hit), .lkp_static(lkp_static),
        .lkp_mask(lkp_mask), .lkp_vid(lkp_vid), .port_vids(port_vids),
        .srv_mask(srv_mask), .cpu_bcast_en(cpu_bcast_en),
        .xvlan_cpu_en(xvlan_cpu_en), .out_valid(out_valid), .out_mask(out_mask)
    );

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    // ports 0-7 in VLAN 1, ports 8-15 in VLAN 2
    task automatic set_two_vlans();
        for (int i = 0; i < 16; i++) port_vids[i*6 +: 6] = (i < 8) ? 6'd1 : 6'd2;
    endtask

    task automatic send(logic [3:0] p, logic b, logic h, logic s,
                        logic [16:0] m, logic [5:0] v);
        @(negedge clk);
        in_port = p; is_bcast = b; lkp_hit = h; lkp_static = s;
        lkp_mask = m; lkp_vid = v; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 valid", {16'd0, out_valid}, 17'd1);
    endtask

    task automatic t_reset();
        check("R11 valid", {16'd0, out_valid}, 17'd0);
        check("R11 mask", out_mask, 17'd0);
    endtask

    task automatic t_vlan_bcast();
        set_two_vlans(); srv_mask = '0;
        cpu_bcast_en = 0;
        send(4'd3, 1, 0, 0, '0, 6'd0);
        check("R2 bcast vlan1", out_mask, 17'h000F7);
        cpu_bcast_en = 1;
        send(4'd3, 1, 0, 0, '0, 6'd0);
        check("R4 bcast cpu copy", out_mask, 17'h100F7);
        send(4'd10, 0, 0, 0, '0, 6'd0);
        check("R4 miss no cpu", out_mask, 17'h0FB00);
        send(4'd9, 1, 1, 0, 17'h00001, 6'd1);
        check("R2 bcast over dyn hit", out_mask, 17'h1FD00);
    endtask

    task automatic t_server();
        set_two_vlans(); cpu_bcast_en = 0;
        srv_mask = 16'h8000;
        send(4'd3, 1, 0, 0, '0, 6'd0);
        check("R3 server in vlan1 flood", out_mask, 17'h080F7);
        srv_mask = 16'h0001;
        send(4'd12, 0, 0, 0, '0, 6'd0);
        check("R3 server in vlan2 flood", out_mask, 17'h0EF01);
        srv_mask = '0;
    endtask

    task automatic t_static();
        set_two_vlans(); cpu_bcast_en = 1; xvlan_cpu_en = 1;
        send(4'd3, 1, 1, 1, 17'h00300, 6'd2);
        check("R5 static wins", out_mask, 17'h00300);
        send(4'd3, 0, 1, 1, 17'h00038, 6'd1);
        check("R9 static ingress cleared", out_mask, 17'h00030);
    endtask

    task automatic t_unicast();
        set_two_vlans();
        send(4'd1, 0, 1, 0, 17'h00020, 6'd1);
        check("R7 same vlan", out_mask, 17'h00020);
        xvlan_cpu_en = 1;
        send(4'd1, 0, 1, 0, 17'h00200, 6'd2);
        check("R6 cross to cpu", out_mask, 17'h10000);
        xvlan_cpu_en = 0;
        send(4'd1, 0, 1, 0, 17'h00200, 6'd2);
        check("R6 cross dropped", out_mask, 17'h00000);
    endtask

    task automatic t_vlan_off();
        set_two_vlans(); port_vids[5*6 +: 6] = 6'd0;
        cpu_bcast_en = 0; srv_mask = 16'h8000;
        send(4'd4, 1, 0, 0, '0, 6'd0);
        check("R8 open flood", out_mask, 17'h0FFEF);
        xvlan_cpu_en = 0;
        send(4'd1, 0, 1, 0, 17'h00200, 6'd2);
        check("R1 no vlan filter on hit", out_mask, 17'h00200);
        srv_mask = '0;
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R10 idle valid", {16'd0, out_valid}, 17'd0);
        check("R10 idle holds", out_mask, 17'h00200);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_port = '0; is_bcast = 0; lkp_hit = 0;
        lkp_static = 0; lkp_mask = '0; lkp_vid = '0; port_vids = '0;
        srv_mask = '0; cpu_bcast_en = 0; xvlan_cpu_en = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        t_vlan_bcast();
        t_server();
        t_static();
        t_unicast();
        t_vlan_off();
        t_idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule